// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

This block sits between the memory configuration registers and the SDRAM access path. It receives four packed bank control words and one global enable. For every physical address presented, it decides which bank, if any, owns the address and returns the byte offset of the address inside that bank. Each bank takes its base and its size from its own control word. The base is aligned to 8 MiB. The size is a 3-bit power-of-two code counted in 4 MiB steps.

A bank takes part in decoding only when its own enable bit is set and the global enable is also set. Dropping the global enable takes every bank out of the map in the same cycle. Raising it again brings back every bank whose own bit is still set, because no other state is kept. When banks overlap, a fixed priority selects the lowest-numbered bank. The decode path from address to outputs is combinational. A parameter can add one register stage at the outputs.

Top module: `sdram_bank_decode`

## Requirements
- R1: Control-word bits 31:23 are the bank base, so the base is the value {bits 31:23, 23 zero bits}. An address hits a bank only when its bits at and above the bank's size boundary equal the same bits of the base.
- R2: Control-word bits 19:17 hold a size code c. For c from 0 to 6 the bank spans 4 MiB << c bytes, starting at the base rounded down to a multiple of that size. On a hit, `bank_ofs` is the address minus that aligned start.
- R3: A bank whose size code is 7 never hits, whatever its other bits and the address.
- R4: A bank can hit only when control-word bit 0 is 1 and `glb_en` is 1.
- R5: Clearing `glb_en` removes all banks from the map immediately. Setting it again restores every bank whose bit 0 is set, with the same decode as before.
- R6: When several banks contain the address, only the lowest-numbered one is reported. `hit_vec` bit i stands for bank i and has at most one bit set.
- R7: `any_hit` is 1 exactly when some bank hits. When no bank hits, `hit_vec` and `bank_ofs` are zero.
- R8: With `REG_OUT` = 1, the outputs show the decode of the inputs sampled at the previous rising clock edge, and they are zero while `rst_n` is low. With `REG_OUT` = 0, the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable that gates every bank |
| bank_ctl | input | NBANK*32 | Packed control words, bank i in bits [32*i+31 : 32*i] |
| addr | input | 32 | Physical address to decode |
| hit_vec | output | NBANK | One-hot winning bank, zero on a miss |
| any_hit | output | 1 | Some bank owns the address |
| bank_ofs | output | 32 | Offset within the winning bank, zero on a miss |

## Verification
The bench builds two copies with four banks each: one with `REG_OUT` = 0 and one with `REG_OUT` = 1. Both receive the same stimulus, so the combinational answer and the answer one clock later are compared against the same arithmetic model. Four banks is small enough to sweep every size code, including the invalid one, in every bank position, with addresses at both edges of each window. It also makes it possible to walk all sixteen enable patterns with the global enable on and off, and to stack all four banks on one base so that every overlap pattern exercises the priority.

// File: rtl/sdram_bank_decode.sv
module sdram_bank_decode #(
  parameter int NBANK   = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic [NBANK*32-1:0] bank_ctl,
  input  logic [31:0]        addr,
  output logic [NBANK-1:0]   hit_vec,
  output logic               any_hit,
  output logic [31:0]        bank_ofs
);
  localparam int CW      = 32;
  localparam int BASE_LO = 23;
  localparam int CODE_LO = 17;
  localparam int CODE_W  = 3;
  localparam logic [CW-1:0] UNIT = 32'h0040_0000;
  localparam logic [CODE_W-1:0] BAD_CODE = '1;

  logic [NBANK-1:0] raw, pick;
  logic [CW-1:0]    span_mask [NBANK];
  logic [CW-1:0]    inner     [NBANK];
  logic [CW-1:0]    nxt_ofs;
  logic             nxt_any;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [CW-1:0]     word;
    logic [CODE_W-1:0] code;
    logic [CW-1:0]     base;
    assign word         = bank_ctl[g*CW +: CW];
    assign code         = word[CODE_LO +: CODE_W];
    assign base         = {word[CW-1:BASE_LO], {BASE_LO{1'b0}}};
    assign span_mask[g] = (UNIT << code) - 32'd1;
    assign inner[g]     = addr & span_mask[g];
    assign raw[g]       = glb_en & word[0] & (code != BAD_CODE) &
                          ((addr & ~span_mask[g]) == (base & ~span_mask[g]));

    assert_code7_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (code == BAD_CODE) |-> !pick[g]);
    assert_ofs_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pick[g] |-> ((nxt_ofs & ~span_mask[g]) == '0));
  end

  assign pick    = raw & (~raw + NBANK'(1));
  assign nxt_any = |raw;

  always_comb begin
    nxt_ofs = '0;
    for (int i = 0; i < NBANK; i++)
      if (pick[i]) nxt_ofs = nxt_ofs | inner[i];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_vec  <= '0;
        any_hit  <= 1'b0;
        bank_ofs <= '0;
      end else begin
        hit_vec  <= pick;
        any_hit  <= nxt_any;
        bank_ofs <= nxt_ofs;
      end
    end
  end else begin : g_comb
    assign hit_vec  = pick;
    assign any_hit  = nxt_any;
    assign bank_ofs = nxt_ofs;
  end

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));
  assert_glb_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (pick == '0));
  assert_any_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_any == (pick != '0));
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (bank_ofs == '0 && hit_vec == '0));
endmodule

// File: tb/test_sdram_bank_decode.sv
module test_sdram_bank_decode;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         glb_en = 1'b0;
  logic [127:0] bank_ctl = '0;
  logic [31:0]  addr = '0;
  logic [3:0]   c_hit, r_hit;
  logic         c_any, r_any;
  logic [31:0]  c_ofs, r_ofs;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_bank_decode #(.NBANK(4), .REG_OUT(1'b0)) i_sdram_bank_decode (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .bank_ctl(bank_ctl), .addr(addr),
    .hit_vec(c_hit), .any_hit(c_any), .bank_ofs(c_ofs));

  sdram_bank_decode #(.NBANK(4), .REG_OUT(1'b1)) i_sdram_bank_decode_reg (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .bank_ctl(bank_ctl), .addr(addr),
    .hit_vec(r_hit), .any_hit(r_any), .bank_ofs(r_ofs));

  function automatic logic [31:0] mkctl(input logic [31:0] base, input int code, input bit en);
    return (base & 32'hFF80_0000) | (32'(code) << 17) | {31'd0, en};
  endfunction

  task automatic model(output logic [3:0] eh, output logic [31:0] eo);
    eh = '0; eo = '0;
    for (int i = 3; i >= 0; i--) begin
      logic [31:0] w;
      longint sz, b, eb, a;
      w = bank_ctl[i*32 +: 32];
      a = longint'(addr);
      if (glb_en && w[0] && w[19:17] != 3'd7) begin
        sz = longint'(4194304) << w[19:17];
        b  = longint'(w & 32'hFF80_0000);
        eb = b - (b % sz);
        if (a >= eb && a < eb + sz) begin
          eh = 4'(1 << i);
          eo = 32'(a - eb);
        end
      end
    end
  endtask

  task automatic cmp(input string tag, input logic [3:0] h, input logic an, input logic [31:0] o,
                     input logic [3:0] eh, input logic [31:0] eo);
    checks++;
    if (h !== eh || an !== (|eh) || o !== eo) begin
      errors++;
      $display("FAIL %s addr=%h actual hit=%b any=%b ofs=%h expected hit=%b any=%b ofs=%h",
               tag, addr, h, an, o, eh, |eh, eo);
    end
  endtask

  task automatic apply(input logic [127:0] ctl, input logic g, input logic [31:0] a, input string tag);
    logic [3:0] eh;
    logic [31:0] eo;
    @(negedge clk);
    bank_ctl = ctl; glb_en = g; addr = a;
    #2;
    model(eh, eo);
    cmp((eh == 0) ? "R7" : tag, c_hit, c_any, c_ofs, eh, eo);
    @(posedge clk);
    #2;
    cmp("R8", r_hit, r_any, r_ofs, eh, eo);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] ctl;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (r_hit !== 0 || r_any !== 0 || r_ofs !== 0) begin
      errors++;
      $display("FAIL R8 reset actual hit=%b any=%b ofs=%h expected 0 0 0", r_hit, r_any, r_ofs);
    end
    @(negedge clk) rst_n = 1'b1;

    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 8; c++) begin
        longint sz, eb;
        sz = longint'(4194304) << c;
        eb = 64'h3080_0000 - (64'h3080_0000 % sz);
        ctl = '0;
        ctl[b*32 +: 32] = mkctl(32'h3080_0000, c, 1'b1);
        apply(ctl, 1'b1, 32'(eb - 1),      c == 7 ? "R3" : "R1");
        apply(ctl, 1'b1, 32'(eb),          c == 7 ? "R3" : "R2");
        apply(ctl, 1'b1, 32'(eb + sz / 2 + 12), c == 7 ? "R3" : "R2");
        apply(ctl, 1'b1, 32'(eb + sz - 1), c == 7 ? "R3" : "R2");
        apply(ctl, 1'b1, 32'(eb + sz),     c == 7 ? "R3" : "R1");
        apply(ctl, 1'b1, 32'h3080_0000,    c == 7 ? "R3" : "R1");
      end

    for (int k = 0; k < 512; k += 37) begin
      ctl = '0;
      ctl[31:0] = mkctl(32'(k) << 23, 0, 1'b1);
      apply(ctl, 1'b1, (32'(k) << 23) + 32'h10, "R1");
      apply(ctl, 1'b1, (32'(k) << 23) + 32'h0040_0000, "R1");
    end

    for (int p = 0; p < 16; p++)
      for (int g = 0; g < 2; g++)
        for (int b = 0; b < 4; b++) begin
          ctl = '0;
          for (int i = 0; i < 4; i++)
            ctl[i*32 +: 32] = mkctl(32'(i) << 26, 3, p[i]);
          apply(ctl, g[0], (32'(b) << 26) + 32'h0123_4560, "R4");
        end

    ctl = '0;
    for (int i = 0; i < 4; i++) ctl[i*32 +: 32] = mkctl(32'(i) << 26, 3, 1'b1);
    apply(ctl, 1'b1, 32'h0800_0abc, "R5");
    apply(ctl, 1'b0, 32'h0800_0abc, "R5");
    apply(ctl, 1'b0, 32'h0C00_0abc, "R5");
    apply(ctl, 1'b1, 32'h0800_0abc, "R5");
    apply(ctl, 1'b1, 32'h0C00_0abc, "R5");

    for (int p = 0; p < 16; p++) begin
      ctl = '0;
      for (int i = 0; i < 4; i++) ctl[i*32 +: 32] = mkctl(32'h4000_0000, i, p[i]);
      apply(ctl, 1'b1, 32'h4000_0040, "R6");
      apply(ctl, 1'b1, 32'h4050_0000, "R6");
      apply(ctl, 1'b1, 32'h40A0_0000, "R6");
      apply(ctl, 1'b1, 32'h4140_0000, "R6");
      apply(ctl, 1'b1, 32'h4200_0000, "R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule